// File: doc/BRIEF.md
# PHY Management Master with Background Polling

This block drives a two-wire PHY management bus: a clock output (MDC) made from the system clock by a programmable divider, and a bidirectional data line split into `mdio_o`, `mdio_oe` and `mdio_i`. Software starts a single clause-22 read or write through one user-access register and polls its GO bit until the hardware clears it. For reads, the answer comes back in the same register together with an ACK flag.

When scanning is enabled, a background engine reads the status register (register 1) of PHY addresses 0 to `SCAN_N-1` in turn. It keeps two bitmaps. The alive bitmap shows which addresses answer. The link bitmap holds the link bit reported by each answering PHY.

Arbitration happens only at frame boundaries. A user request never aborts a poll already on the wire, and it is served before the next poll starts. Clearing the enable bit lets the current poll finish and then raises an IDLE flag.

Top module: `mdio_poll_master`

## Requirements
- R1: After reset, the registers read as follows:
  - Offset 0x00 (version) holds `{16'h0, VER_MAJOR, VER_MINOR}`.
  - Offset 0x04 (control) holds IDLE=1 in bit 31, ENABLE=0 in bit 30 and `DIV_RST` in bits 15:0.
  - Offsets 0x08 (alive) and 0x0C (link) read 0.
  - Offset 0x80 (user access) reads 0.
- R2: One MDC period lasts divider+1 system clocks. A divider of 0 behaves as 1. MDC rises only at the mid-period point of the divider.
- R3: The user-access word has GO in bit 31, WRITE in bit 30 (0 = read), ACK in bit 29, the PHY register number in bits 25:21, the PHY address in bits 20:16 and data in bits 15:0. Writing it with GO=1 starts a frame. GO clears by itself when the frame ends.
- R4: GO reads 1 from the cycle after the request until the frame completes. A user-access write made while GO is 1 has no effect.
- R5: Every frame has the following layout:
  - 32 preamble ones.
  - Start bits 01.
  - Opcode 10 for a read or 01 for a write.
  - The 5-bit PHY address, then the 5-bit register number, MSB first.
  - Two turnaround bits, driven as 10 on writes.
  - 16 data bits, MSB first.
  The master changes `mdio_o` only right after MDC falls.
- R6: On reads, the master releases the line from the first turnaround bit onward. ACK is set when the PHY pulls the second turnaround bit low. The data field then holds the 16 bits sampled on the rising edges of MDC.
- R7: While scanning, each completed poll of address N sets alive bit N if that PHY answered and clears it otherwise. Alive bits change at no other time.
- R8: Each poll sets link bit N to bit 2 of the status register returned by PHY N. If PHY N does not answer, link bit N is cleared.
- R9: A pending user request is served before the next poll starts. It waits for at most one poll already in progress.
- R10: Clearing ENABLE stops polling once the current poll ends. After that, IDLE reads 1 and the bitmaps hold their values. Setting ENABLE again resumes polling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Master drives the data line when 1 |
| mdio_i | input | 1 | Resolved data line value |

## Verification
The bench builds the block with `SCAN_N=4` and `DIV_RST=3`.

`SCAN_N=4` keeps a full polling pass to about a thousand cycles. This puts several of the following within a few thousand cycles:
- alive and link bits being set and cleared;
- bitmaps frozen while scanning is disabled;
- user requests that collide with polls at several phase offsets.

`DIV_RST=3` gives a four-clock MDC. That is short enough to walk a table of reads and writes against a PHY model that holds a register file, answers only at chosen addresses, and flags framing errors and bus contention.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int DRIVE_RD   = 46;  // bits driven by the master on a read
  localparam int TA2_POS    = 47;  // second turnaround bit
  localparam int DATA_POS   = 48;  // first data bit

  localparam logic [7:0] OFF_VER   = 8'h00;
  localparam logic [7:0] OFF_CTL   = 8'h04;
  localparam logic [7:0] OFF_ALIVE = 8'h08;
  localparam logic [7:0] OFF_LINK  = 8'h0C;
  localparam logic [7:0] OFF_USER  = 8'h80;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } mdio_cmd_t;

  // Full 64-bit serial image, MSB sent first.
  function automatic logic [63:0] build_frame(mdio_cmd_t c);
    return {32'hFFFF_FFFF, 2'b01, (c.wr ? 2'b01 : 2'b10), c.phy, c.regad,
            (c.wr ? 2'b10 : 2'b11), c.data};
  endfunction

  function automatic logic [15:0] eff_div(logic [15:0] d);
    return (d == 16'd0) ? 16'd1 : d;
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] div,
  output logic        rise_tick,
  output logic        fall_tick,
  output logic        mdc
);
  logic [15:0] cnt;
  logic [15:0] dv;

  assign dv        = eff_div(div);
  assign fall_tick = (cnt >= dv);
  assign rise_tick = (cnt == (dv >> 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_tick ? 16'd0 : cnt + 16'd1;
      if (fall_tick)      mdc <= 1'b0;
      else if (rise_tick) mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        ack,
  output logic [15:0] rdata,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [63:0] frame;
  logic [5:0]  idx;
  logic        is_rd;

  assign done    = fall_tick && busy && (idx == 6'(FRAME_BITS - 1));
  assign mdio_o  = busy ? frame[6'd63 - idx] : 1'b1;
  assign mdio_oe = busy && (!is_rd || (idx < 6'(DRIVE_RD)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      frame <= '1;
      is_rd <= 1'b0;
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      if (fall_tick) begin
        if (busy) begin
          if (done) busy <= 1'b0;
          else      idx  <= idx + 6'd1;
        end else if (start) begin
          busy  <= 1'b1;
          idx   <= '0;
          frame <= build_frame(cmd);
          is_rd <= !cmd.wr;
          ack   <= 1'b0;
        end
      end
      if (rise_tick && busy && is_rd) begin
        if (idx == 6'(TA2_POS)) ack <= !mdio_i;
        if (idx >= 6'(DATA_POS)) rdata <= {rdata[14:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_poll_master.sv
module mdio_poll_master
  import mdio_pkg::*;
#(
  parameter int          SCAN_N    = 32,
  parameter logic [15:0] DIV_RST   = 16'd255,
  parameter logic [7:0]  VER_MAJOR = 8'd1,
  parameter logic [7:0]  VER_MINOR = 8'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int SA_W = (SCAN_N > 1) ? $clog2(SCAN_N) : 1;
  localparam logic [SA_W-1:0] SA_LAST = SA_W'(SCAN_N - 1);

  logic            en;
  logic [15:0]     div;
  logic            go;
  mdio_cmd_t       u_cmd;
  logic            u_ack;
  logic [31:0]     alive;
  logic [31:0]     link;
  logic [SA_W-1:0] scan_addr;
  logic            cur_user;
  logic            idle_flag;

  logic            rise_tick, fall_tick;
  logic            eng_busy, eng_done, eng_ack, eng_start;
  logic [15:0]     eng_rdata;
  mdio_cmd_t       scan_cmd, eng_cmd;
  logic            wr_ctl, wr_user;
  logic            wdata_unused;

  assign wdata_unused = ^bus_wdata[29:26];

  assign wr_ctl  = bus_sel && bus_we && (bus_addr == OFF_CTL);
  assign wr_user = bus_sel && bus_we && (bus_addr == OFF_USER) && bus_wdata[31] && !go;

  assign scan_cmd  = '{wr: 1'b0, phy: 5'(scan_addr), regad: 5'd1, data: 16'h0};
  assign eng_cmd   = go ? u_cmd : scan_cmd;
  assign eng_start = fall_tick && !eng_busy && (go || en);
  assign idle_flag = !en && !(eng_busy && !cur_user);

  mdio_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .div(div),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdc(mdc)
  );

  mdio_engine u_eng (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .start(eng_start), .cmd(eng_cmd), .mdio_i(mdio_i),
    .busy(eng_busy), .done(eng_done), .ack(eng_ack), .rdata(eng_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      div       <= DIV_RST;
      go        <= 1'b0;
      u_cmd     <= '0;
      u_ack     <= 1'b0;
      alive     <= '0;
      link      <= '0;
      scan_addr <= '0;
      cur_user  <= 1'b0;
    end else begin
      if (wr_ctl) begin
        en  <= bus_wdata[30];
        div <= bus_wdata[15:0];
      end
      if (wr_user) begin
        go    <= 1'b1;
        u_ack <= 1'b0;
        u_cmd <= '{wr: bus_wdata[30], regad: bus_wdata[25:21],
                   phy: bus_wdata[20:16], data: bus_wdata[15:0]};
      end
      if (eng_start) cur_user <= go;
      if (eng_done) begin
        if (cur_user) begin
          go <= 1'b0;
          if (!u_cmd.wr) begin
            u_ack      <= eng_ack;
            u_cmd.data <= eng_rdata;
          end
        end else begin
          alive[5'(scan_addr)] <= eng_ack;
          link[5'(scan_addr)]  <= eng_ack && eng_rdata[2];
          scan_addr <= (scan_addr == SA_LAST) ? '0 : scan_addr + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_VER:   bus_rdata = {16'h0, VER_MAJOR, VER_MINOR};
      OFF_CTL:   bus_rdata = {idle_flag, en, 14'h0, div};
      OFF_ALIVE: bus_rdata = alive;
      OFF_LINK:  bus_rdata = link;
      OFF_USER:  bus_rdata = {go, u_cmd.wr, u_ack, 3'b000, u_cmd.regad,
                              u_cmd.phy, u_cmd.data};
      default:   bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/mdio_poll_master_chk.sv
module mdio_poll_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        go,
  input logic        en,
  input logic        cur_user,
  input logic        eng_start,
  input logic        eng_done,
  input logic        eng_busy,
  input logic        rise_tick,
  input logic        fall_tick,
  input logic        mdc,
  input logic        mdio_o,
  input logic [31:0] alive
);
  // R4
  go_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !(eng_done && cur_user)) |=> go);

  // R9
  user_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && go) |=> (eng_busy && cur_user));

  // R10
  scan_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !go) |-> en);

  // R2
  mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(rise_tick));

  // R5
  mdio_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_o != $past(mdio_o)) |-> $past(fall_tick));

  // R7
  alive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_done && !cur_user) |=> $stable(alive));
endmodule

bind mdio_poll_master mdio_poll_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .en(en), .cur_user(cur_user),
  .eng_start(eng_start), .eng_done(eng_done), .eng_busy(eng_busy),
  .rise_tick(rise_tick), .fall_tick(fall_tick), .mdc(mdc),
  .mdio_o(mdio_o), .alive(alive)
);

// File: tb/mdio_poll_master_bench.sv
module mdio_poll_master_bench;
  localparam logic [7:0] A_VER = 8'h00, A_CTL = 8'h04, A_ALV = 8'h08,
                         A_LNK = 8'h0C, A_USR = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_oe = 1'b0, phy_o = 1'b1;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_poll_master #(.SCAN_N(4), .DIV_RST(16'd3)) u_mdio_poll_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- PHY model ----------------
  logic [31:0] present = 32'h0000_000A;
  logic [31:0] linkup  = 32'h0000_0008;
  logic [15:0] mem [32];
  int   st = 0, ones = 0, nb = 0, cnt = 0, rc = 0;
  int   fmt_err = 0, conflict = 0, nwr = 0;
  logic [12:0] hdr;
  logic [17:0] wb;
  logic [4:0]  ph, rg;
  logic [25:0] lw;
  logic [15:0] rdv;

  initial for (int i = 0; i < 32; i++) mem[i] = 16'h0;

  assign rdv = (rg == 5'd1) ? (16'h7809 | (linkup[ph] ? 16'h0004 : 16'h0)) : mem[rg];

  always @(posedge mdc) begin
    if (mdio_oe && phy_oe) conflict++;
    case (st)
      0: if (mdio_i) begin
           if (ones < 100) ones++;
         end else begin
           if (ones >= 32) begin st = 1; nb = 0; hdr = '0; end
           ones = 0;
         end
      1: begin
           hdr = {hdr[11:0], mdio_i};
           nb++;
           if (nb == 13) begin
             if (hdr[12] !== 1'b1) fmt_err++;
             ph = hdr[9:5]; rg = hdr[4:0]; cnt = 0; wb = '0;
             if (hdr[11:10] == 2'b10) st = 2;
             else if (hdr[11:10] == 2'b01) st = 3;
             else begin fmt_err++; st = 0; end
           end
         end
      2: begin
           cnt++;
           if (cnt == 18) st = 0;
         end
      default: begin
           wb = {wb[16:0], mdio_i};
           cnt++;
           if (cnt == 18) begin
             if (wb[17:16] != 2'b10) fmt_err++;
             if (present[ph]) begin
               if (rg != 5'd1) mem[rg] = wb[15:0];
               lw = {ph, rg, wb[15:0]};
               nwr++;
             end
             st = 0;
           end
         end
    endcase
  end

  always @(negedge mdc) begin
    if (st == 2 && present[ph]) begin
      if (rc == 0) phy_oe = 1'b0;
      else if (rc == 1) begin phy_oe = 1'b1; phy_o = 1'b0; end
      else if (rc < 18) begin phy_oe = 1'b1; phy_o = rdv[17 - rc]; end
      rc++;
    end else begin
      phy_oe = 1'b0;
      rc = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_go(input int lim, output int cyc);
    logic [31:0] d;
    cyc = 0;
    do begin
      bus_rd(A_USR, d);
      cyc++;
    end while (d[31] && cyc < lim);
  endtask

  task automatic meas(output int p);
    longint t0, t1;
    @(posedge mdc); @(posedge mdc);
    t0 = longint'($time);
    @(posedge mdc);
    t1 = longint'($time);
    p = int'((t1 - t0) / 8);
  endtask

  function automatic logic [31:0] uword(logic wr, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {1'b1, wr, 1'b0, 3'b000, r, p, d};
  endfunction

  // {wr, phy, reg, wdata, exp_ack, exp_data}
  localparam logic [43:0] VECS [8] = '{
    {1'b1, 5'd1,  5'd4,  16'hABCD, 1'b0, 16'h0000},
    {1'b0, 5'd1,  5'd4,  16'h0000, 1'b1, 16'hABCD},
    {1'b1, 5'd3,  5'd9,  16'h1234, 1'b0, 16'h0000},
    {1'b0, 5'd3,  5'd9,  16'h0000, 1'b1, 16'h1234},
    {1'b0, 5'd2,  5'd4,  16'h0000, 1'b0, 16'h0000},
    {1'b0, 5'd3,  5'd1,  16'h0000, 1'b1, 16'h780D},
    {1'b0, 5'd1,  5'd1,  16'h0000, 1'b1, 16'h7809},
    {1'b0, 5'd31, 5'd31, 16'h0000, 1'b0, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p, cyc;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state and offsets
    bus_rd(A_VER, d); check("R1 version", d, 32'h0000_0100);
    bus_rd(A_CTL, d); check("R1 control", d, 32'h8000_0003);
    bus_rd(A_ALV, d); check("R1 alive", d, 32'h0);
    bus_rd(A_LNK, d); check("R1 link", d, 32'h0);
    bus_rd(A_USR, d); check("R1 user", d, 32'h0);

    // R2 MDC period = divider + 1, zero treated as one
    bus_wr(A_CTL, 32'h0000_0005); meas(p); check("R2 period div5", 32'(p), 32'd6);
    bus_wr(A_CTL, 32'h0000_0000); meas(p); check("R2 period div0", 32'(p), 32'd2);
    bus_wr(A_CTL, 32'h0000_0003); meas(p); check("R2 period div3", 32'(p), 32'd4);

    // R3 / R5 / R6 vector table
    foreach (VECS[i]) begin
      logic [43:0] v;
      int wr0;
      v = VECS[i];
      wr0 = nwr;
      bus_wr(A_USR, uword(v[43], v[42:38], v[37:33], v[32:17]));
      bus_rd(A_USR, d); check("R4 go set while pending", 32'(d[31]), 32'd1);
      wait_go(600, cyc);
      check("R3 go self-clears", 32'(cyc < 600), 32'd1);
      bus_rd(A_USR, d);
      if (v[43]) begin
        check("R5 write reached phy", 32'(nwr - wr0), 32'd1);
        check("R5 write fields", {6'h0, lw}, {6'h0, v[42:38], v[37:33], v[32:17]});
      end else begin
        check("R6 read ack", 32'(d[29]), 32'(v[16]));
        if (v[16]) check("R6 read data", {16'h0, d[15:0]}, {16'h0, v[15:0]});
      end
    end
    check("R5 frame format errors", 32'(fmt_err), 32'd0);
    check("R6 line contention", 32'(conflict), 32'd0);

    // R4 write while GO set is ignored
    bus_wr(A_USR, uword(1'b1, 5'd1, 5'd6, 16'h1111));
    bus_wr(A_USR, uword(1'b1, 5'd3, 5'd7, 16'h2222));
    wait_go(600, cyc);
    bus_rd(A_USR, d);
    check("R4 ignored write fields", {6'h0, d[25:0]}, {6'h0, 5'd6, 5'd1, 16'h1111});
    check("R4 phy saw first write", {6'h0, lw}, {6'h0, 5'd1, 5'd6, 16'h1111});
    check("R4 phy reg7 untouched", {16'h0, mem[7]}, 32'h0);

    // R7 / R8 scanning
    bus_wr(A_CTL, 32'h4000_0003);
    repeat (2400) @(posedge clk);
    bus_rd(A_ALV, d); check("R7 alive set", d, 32'h0000_000A);
    bus_rd(A_LNK, d); check("R8 link bits", d, 32'h0000_0008);
    present = 32'h0000_0008; linkup = 32'h0;
    repeat (2400) @(posedge clk);
    bus_rd(A_ALV, d); check("R7 alive cleared", d, 32'h0000_0008);
    bus_rd(A_LNK, d); check("R8 link cleared", d, 32'h0);

    // R9 user request during scanning, several phases
    for (int k = 0; k < 3; k++) begin
      repeat (37 * k + 5) @(posedge clk);
      bus_wr(A_USR, uword(1'b0, 5'd3, 5'd9, 16'h0));
      wait_go(600, cyc);
      check("R9 served within one poll", 32'(cyc <= 540), 32'd1);
      bus_rd(A_USR, d);
      check("R9 read result", {15'h0, d[29], d[15:0]}, {15'h0, 1'b1, 16'h1234});
    end

    // R10 disable / idle / freeze / re-enable
    bus_rd(A_CTL, d); check("R10 busy while enabled", 32'(d[31]), 32'd0);
    bus_wr(A_CTL, 32'h0000_0003);
    cyc = 0;
    do begin bus_rd(A_CTL, d); cyc++; end while (!d[31] && cyc < 400);
    check("R10 idle after stop", 32'(d[31]), 32'd1);
    present = 32'h0000_000A;
    repeat (1500) @(posedge clk);
    bus_rd(A_ALV, d); check("R10 alive frozen", d, 32'h0000_0008);
    bus_wr(A_CTL, 32'h4000_0003);
    repeat (2400) @(posedge clk);
    bus_rd(A_ALV, d); check("R10 scanning resumed", d, 32'h0000_000A);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule